// File: doc/BRIEF.md
# Strobed parallel port handshake controller

This block runs two 8-bit parallel ports. Port C is bidirectional and port B is output-only. One input strobe pin and one output strobe pin sit beside the ports. A control register selects the protocol:

- **Simple strobed mode:** each active edge on the input strobe captures port C into a latch register, and each write to port B pulses the output strobe.
- **Input handshake mode:** the output strobe acts as a ready line for an external writer.
- **Output handshake mode:** the input strobe acts as an acknowledge, and can force every port C pin to drive (the three-state variation).

A status flag records strobe events and drives an active-low interrupt through an enable bit. The flag is cleared by a two-step software sequence that depends on the mode.

The host reaches the block through already-decoded register strobes. A 3-bit select code, a one-cycle read strobe and a one-cycle write strobe mark each access. Every access completes in the cycle it is presented, so there is no back-pressure. Read data is combinational from the current state, and the side effects of an access (flag arming, flag clearing, ready changes) take place at the clock edge that ends the access. The clock is the bus enable clock.

The pad-side outputs are per-pin output data and output enables. Pad electrical behaviour and address decoding are outside the block.

Top module: `pport_ctrl`

## Requirements
- R1: After reset:
  - the control register reads 0x03;
  - the port C output, direction and port B registers read 0;
  - the output strobe is low;
  - the interrupt output is high;
  - no port C pin is enabled.
- R2: Select codes are 0 control, 1 port C, 2 port B, 3 latch, 4 direction. Control bits, from bit 7 down, are: status flag, interrupt enable, open-drain, handshake enable, output-handshake select, pulse select, rising-edge select, strobe non-invert. Bits 6..0 are writable, and bit 7 is read-only, so writing 0xC3 reads back 0x43.
- R3: With the rising-edge select at 1, a rising input-strobe edge copies the port C pin levels into the latch and sets the status flag. A falling edge does neither. Capture continues while the flag is already set.
- R4: The interrupt output is low exactly when the status flag and the interrupt enable are both 1.
- R5: Outside output handshake, the flag clears only when a latch read follows a control read made with the flag set. A latch read without that preceding control read leaves the flag set.
- R6: In output handshake, the second clearing step is a latch write instead (a latch read does not clear). A latch write also loads the port C output register.
- R7: With handshake disabled, every port B write makes the output strobe active for two clock cycles.
- R8: In input handshake with interlock, the ready strobe is inactive after the control write until a latch read asserts it. It then stays active until the next active input-strobe edge.
- R9: In input handshake with pulse select, a latch read asserts ready for exactly two clock cycles.
- R10: In output handshake, a port C write asserts ready. An active acknowledge edge deasserts it and sets the status flag.
- R11: With strobe non-invert at 0, the output strobe idles high and is driven low while active.
- R12: In output handshake, all port C pins are enabled while the acknowledge input is asserted (low when rising-edge select is 1). While it is negated, the pins follow the direction register. In this mode, port C reads return the output register for every bit.
- R13: Outside output handshake, pin enables follow the direction register. A port C read returns the output register for output bits and the pin level for input bits.
- R14: With open-drain set, an output bit is enabled only when its data bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Enable clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select code |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| strobe_in | input | 1 | Input strobe / acknowledge pin |
| strobe_out | output | 1 | Output strobe / ready pin |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output data |
| pc_oe | output | 8 | Port C per-pin output enable |
| pb_out | output | 8 | Port B output data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is a status flag that must survive an incomplete clearing sequence. One case is a latch read with no control read before it. Another is a latch read in output handshake mode, where only a latch write counts. The stimulus sets the flag with a real strobe edge and then interleaves reads and writes in the wrong order, reading the control register each time to observe the flag. It then completes the correct sequence. A second hard spot is the three-state override: the acknowledge level is held in its asserted state while no edge occurs, and pin enables are checked before and after the level changes.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_PORTC = 3'd1,
    SEL_PORTB = 3'd2,
    SEL_LATCH = 3'd3,
    SEL_DIR   = 3'd4
  } reg_sel_e;

  // stored control bit positions (bit 7 is the live status flag)
  localparam int B_IE    = 6;
  localparam int B_OD    = 5;
  localparam int B_HS    = 4;
  localparam int B_OUT   = 3;
  localparam int B_PLS   = 2;
  localparam int B_RISE  = 1;
  localparam int B_NOINV = 0;

  localparam logic [6:0] CTRL_RST = 7'h03;
endpackage

// File: rtl/pport_flag.sv
module pport_flag #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_in,
  input  logic          rise,
  input  logic          out_hs,
  input  logic          rd_ctrl,
  input  logic          rd_latch,
  input  logic          wr_latch,
  input  logic [DW-1:0] pins,
  output logic          act_edge,
  output logic          flag,
  output logic [DW-1:0] latch
);
  logic st_q;
  logic armed;
  logic clr_step;

  assign act_edge = rise ? (strobe_in & ~st_q) : (~strobe_in & st_q);
  assign clr_step = armed & (out_hs ? wr_latch : rd_latch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= strobe_in;
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      st_q <= strobe_in;
      if (act_edge)      flag <= 1'b1;
      else if (clr_step) flag <= 1'b0;
      if (clr_step)             armed <= 1'b0;
      else if (rd_ctrl && flag) armed <= 1'b1;
    end
  end

  // capture register is deliberately left out of reset
  always_ff @(posedge clk) begin
    if (act_edge) latch <= pins;
  end
endmodule

// File: rtl/pport_strobe.sv
module pport_strobe #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_hs,
  input  logic mode_out,
  input  logic mode_pulse,
  input  logic noinv,
  input  logic wr_ctrl,
  input  logic wr_portb,
  input  logic wr_portc_any,
  input  logic rd_latch,
  input  logic act_edge,
  output logic active,
  output logic strobe_out
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic          trigger;
  logic          timed;
  logic [CW-1:0] cnt;

  assign trigger = !mode_hs ? wr_portb : (mode_out ? wr_portc_any : rd_latch);
  assign timed   = !mode_hs | mode_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (wr_ctrl) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (trigger) begin
      active <= 1'b1;
      cnt    <= timed ? CW'(PULSE_CYCLES) : '0;
    end else if (mode_hs && act_edge) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cnt != '0) begin
      if (cnt == CW'(1)) active <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

  assign strobe_out = noinv ? active : ~active;
endmodule

// File: rtl/pport_pins.sv
module pport_pins #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] dir,
  input  logic          od,
  input  logic          tri_mode,
  input  logic          rise,
  input  logic          strobe_in,
  input  logic [DW-1:0] pins_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic [DW-1:0] read_val
);
  logic          ack_on;
  logic          force_drv;
  logic [DW-1:0] dir_eff;

  assign ack_on    = rise ? ~strobe_in : strobe_in;
  assign force_drv = tri_mode & ack_on;
  assign dir_eff   = force_drv ? {DW{1'b1}} : dir;
  assign pc_out    = data;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign pc_oe[i]    = dir_eff[i] & (~od | ~data[i]);
    assign read_val[i] = (tri_mode | dir[i]) ? data[i] : pins_in[i];
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          strobe_in,
  output logic          strobe_out,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic [DW-1:0] pb_out,
  output logic          irq_n
);
  reg_sel_e      sel;
  logic [6:0]    ctrl;
  logic [DW-1:0] portc_q, portb_q, dir_q;
  logic          flag, act_edge, active;
  logic [DW-1:0] latch_q, pc_read;
  logic          wr_ctrl, wr_portc, wr_portb, wr_latch, wr_dir;
  logic          rd_ctrl, rd_latch;
  logic          out_hs;

  assign sel      = reg_sel_e'(reg_sel);
  assign wr_ctrl  = reg_wr && sel == SEL_CTRL;
  assign wr_portc = reg_wr && sel == SEL_PORTC;
  assign wr_portb = reg_wr && sel == SEL_PORTB;
  assign wr_latch = reg_wr && sel == SEL_LATCH;
  assign wr_dir   = reg_wr && sel == SEL_DIR;
  assign rd_ctrl  = reg_rd && sel == SEL_CTRL;
  assign rd_latch = reg_rd && sel == SEL_LATCH;
  assign out_hs   = ctrl[B_HS] & ctrl[B_OUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST;
      portc_q <= '0;
      portb_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_ctrl)              ctrl    <= reg_wdata[6:0];
      if (wr_portc || wr_latch) portc_q <= reg_wdata;
      if (wr_portb)             portb_q <= reg_wdata;
      if (wr_dir)               dir_q   <= reg_wdata;
    end
  end

  pport_flag #(.DW(DW)) i_flag (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .rise(ctrl[B_RISE]),
    .out_hs(out_hs), .rd_ctrl(rd_ctrl), .rd_latch(rd_latch),
    .wr_latch(wr_latch), .pins(pc_in), .act_edge(act_edge), .flag(flag),
    .latch(latch_q)
  );

  pport_strobe #(.PULSE_CYCLES(PULSE_CYCLES)) i_strobe (
    .clk(clk), .rst_n(rst_n), .mode_hs(ctrl[B_HS]), .mode_out(ctrl[B_OUT]),
    .mode_pulse(ctrl[B_PLS]), .noinv(ctrl[B_NOINV]), .wr_ctrl(wr_ctrl),
    .wr_portb(wr_portb), .wr_portc_any(wr_portc | wr_latch),
    .rd_latch(rd_latch), .act_edge(act_edge), .active(active),
    .strobe_out(strobe_out)
  );

  pport_pins #(.DW(DW)) i_pins (
    .data(portc_q), .dir(dir_q), .od(ctrl[B_OD]), .tri_mode(out_hs),
    .rise(ctrl[B_RISE]), .strobe_in(strobe_in), .pins_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .read_val(pc_read)
  );

  always_comb begin
    case (sel)
      SEL_CTRL:  reg_rdata = {flag, ctrl};
      SEL_PORTC: reg_rdata = pc_read;
      SEL_PORTB: reg_rdata = portb_q;
      SEL_LATCH: reg_rdata = latch_q;
      SEL_DIR:   reg_rdata = dir_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign pb_out = portb_q;
  assign irq_n  = ~(flag & ctrl[B_IE]);
endmodule

// File: rtl/pport_sva.sv
module pport_sva #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_in,
  input logic          rise,
  input logic          flag,
  input logic          ie,
  input logic          irq_n,
  input logic          active,
  input logic          hs,
  input logic          out_sel,
  input logic          od,
  input logic          wr_ctrl,
  input logic [DW-1:0] pc_oe,
  input logic [DW-1:0] pc_out
);
  logic prev_st, past_ok, seen_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_st <= strobe_in;
      past_ok <= 1'b0;
    end else begin
      prev_st <= strobe_in;
      past_ok <= 1'b1;
    end
  end

  assign seen_edge = past_ok && (rise ? (strobe_in && !prev_st) : (!strobe_in && prev_st));

  a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |=> flag);

  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag && ie));

  a_r7_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && !hs && !wr_ctrl) |=> active);

  a_r12_ack_forces_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_sel && !od && (rise ? !strobe_in : strobe_in)) |-> (pc_oe == {DW{1'b1}}));

  a_r14_od_no_high_drive: assert property (@(posedge clk) disable iff (!rst_n)
    od |-> ((pc_oe & pc_out) == '0));
endmodule

bind pport_ctrl pport_sva #(.DW(DW)) i_sva (
  .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .rise(ctrl[1]),
  .flag(flag), .ie(ctrl[6]), .irq_n(irq_n), .active(active), .hs(ctrl[4]),
  .out_sel(ctrl[3]), .od(ctrl[5]), .wr_ctrl(wr_ctrl), .pc_oe(pc_oe),
  .pc_out(pc_out)
);

// File: tb/test_pport_ctrl.sv
module test_pport_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_CTRL = 3'd0, S_PC = 3'd1, S_PB = 3'd2, S_LAT = 3'd3, S_DIR = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_sel = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       strobe_in = 1'b0;
  logic       strobe_out;
  logic [7:0] pc_in = '0;
  logic [7:0] pc_out, pc_oe, pb_out;
  logic       irq_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_ctrl i_pport_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strobe_in(strobe_in),
    .strobe_out(strobe_out), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .pb_out(pb_out), .irq_n(irq_n)
  );

  // {is_write, sel, data, expected read}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, S_DIR,  8'hF0, 8'h00},
    {1'b0, S_DIR,  8'h00, 8'hF0},
    {1'b1, S_PC,   8'hA5, 8'h00},
    {1'b0, S_PC,   8'h00, 8'hAC},
    {1'b1, S_PB,   8'h5A, 8'h00},
    {1'b0, S_PB,   8'h00, 8'h5A},
    {1'b1, S_CTRL, 8'hC3, 8'h00},
    {1'b0, S_CTRL, 8'h00, 8'h43},
    {1'b1, S_DIR,  8'h00, 8'h00},
    {1'b0, S_PC,   8'h00, 8'h3C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_st(input logic v);
    @(negedge clk);
    strobe_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    do_rd(S_CTRL, rv); chk("R1 ctrl", rv, 8'h03);
    do_rd(S_PC, rv);   chk("R1 portc", rv, 8'h00);
    do_rd(S_DIR, rv);  chk("R1 dir", rv, 8'h00);
    do_rd(S_PB, rv);   chk("R1 portb", rv, 8'h00);
    chk("R1 strobe/irq/oe", {strobe_out, irq_n, 6'b0}, 8'h40);
    chk("R1 oe", pc_oe, 8'h00);

    // R2 and R13 through the vector table (pc_in = 0x3C)
    pc_in = 8'h3C;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) do_wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        do_rd(VEC[i][18:16], rv);
        chk($sformatf("R2/R13 vector %0d", i), rv, VEC[i][7:0]);
      end
    end
    do_wr(S_CTRL, 8'h03);

    // R3 capture and R5 clearing
    pc_in = 8'h96; set_st(1'b1);
    do_rd(S_CTRL, rv); chk("R3 flag set", rv, 8'h83);
    pc_in = 8'h11; set_st(1'b0);
    do_rd(S_LAT, rv);  chk("R3 falling ignored", rv, 8'h96);
    do_rd(S_CTRL, rv); chk("R5 cleared", rv, 8'h03);
    pc_in = 8'h22; set_st(1'b1); set_st(1'b0);
    pc_in = 8'h33; set_st(1'b1);
    do_rd(S_LAT, rv);  chk("R3 capture while set", rv, 8'h33);
    do_rd(S_CTRL, rv); chk("R5 no clear without arm", rv, 8'h83);
    do_rd(S_LAT, rv);
    do_rd(S_CTRL, rv); chk("R5 clear after arm", rv, 8'h03);
    set_st(1'b0);

    // R4 interrupt
    do_wr(S_CTRL, 8'h43);
    chk("R4 irq idle", {7'b0, irq_n}, 8'h01);
    set_st(1'b1);
    chk("R4 irq low", {7'b0, irq_n}, 8'h00);
    do_wr(S_CTRL, 8'h03);
    chk("R4 irq masked", {7'b0, irq_n}, 8'h01);
    do_rd(S_CTRL, rv); do_rd(S_LAT, rv);
    set_st(1'b0);

    // R7 simple strobe pulse
    do_wr(S_PB, 8'h01); chk("R7 pulse c1", {7'b0, strobe_out}, 8'h01);
    step;               chk("R7 pulse c2", {7'b0, strobe_out}, 8'h01);
    step;               chk("R7 pulse end", {7'b0, strobe_out}, 8'h00);
    // R11 inverted strobe
    do_wr(S_CTRL, 8'h02); chk("R11 idle high", {7'b0, strobe_out}, 8'h01);
    do_wr(S_PB, 8'h02);   chk("R11 active low", {7'b0, strobe_out}, 8'h00);
    step; step;           chk("R11 back high", {7'b0, strobe_out}, 8'h01);

    // R8 input handshake interlocked
    do_wr(S_CTRL, 8'h13); chk("R8 inactive after entry", {7'b0, strobe_out}, 8'h00);
    do_rd(S_LAT, rv);     chk("R8 ready on latch read", {7'b0, strobe_out}, 8'h01);
    step; step; step;     chk("R8 ready held", {7'b0, strobe_out}, 8'h01);
    set_st(1'b1);         chk("R8 edge drops ready", {7'b0, strobe_out}, 8'h00);
    do_rd(S_CTRL, rv); do_rd(S_LAT, rv);
    set_st(1'b0);

    // R9 input handshake pulse
    do_wr(S_CTRL, 8'h17); chk("R9 inactive after entry", {7'b0, strobe_out}, 8'h00);
    do_rd(S_LAT, rv);     chk("R9 pulse c1", {7'b0, strobe_out}, 8'h01);
    step;                 chk("R9 pulse c2", {7'b0, strobe_out}, 8'h01);
    step;                 chk("R9 pulse end", {7'b0, strobe_out}, 8'h00);

    // R10 output handshake, R6 clearing
    do_wr(S_CTRL, 8'h1B);
    do_wr(S_PC, 8'h55);   chk("R10 ready on port write", {7'b0, strobe_out}, 8'h01);
    set_st(1'b1);         chk("R10 ack drops ready", {7'b0, strobe_out}, 8'h00);
    do_rd(S_CTRL, rv);    chk("R10 ack sets flag", rv, 8'h9B);
    do_rd(S_LAT, rv);
    do_rd(S_CTRL, rv);    chk("R6 latch read no clear", rv, 8'h9B);
    do_wr(S_LAT, 8'h77);
    do_rd(S_CTRL, rv);    chk("R6 latch write clears", rv, 8'h1B);

    // R12 three-state variation (dir = 0)
    chk("R12 negated follows dir", pc_oe, 8'h00);
    @(negedge clk); strobe_in = 1'b0; #1;
    chk("R12 asserted forces drive", pc_oe, 8'hFF);
    pc_in = 8'h00;
    do_rd(S_PC, rv);      chk("R6/R12 read output reg", rv, 8'h77);

    // R14 open-drain, R13 enables follow dir
    do_wr(S_CTRL, 8'h23);
    do_wr(S_DIR, 8'hFF);
    do_wr(S_PC, 8'hF0);
    chk("R14 od enables", pc_oe, 8'h0F);
    do_wr(S_CTRL, 8'h03);
    chk("R13 push-pull enables", pc_oe, 8'hFF);
    do_wr(S_DIR, 8'h0F);
    chk("R13 enables follow dir", pc_oe, 8'h0F);
    chk("R2 port B pins", pb_out, 8'h02);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule